// File: doc/BRIEF.md
# Flash Command Sequencer

This block accepts a two-step, byte-coded command protocol on a simple write/read bus and uses it to drive a small register-based flash-like array. The array is split into equal blocks, and each block has one lock bit. The first write on the bus selects an operation by its low data byte. Most operations then need a second write: either the confirm byte D0h, or a 16-bit data word in the case of program. Program, erase, lock-bit program, lock-bit status read and blank check all hold a busy state for a fixed number of cycles. They take effect when that busy time ends. Read-array access and clearing of the error flags happen at once.

Reads are normally served from the array, one byte per access. After a lock-bit status read, bus reads return the captured lock bit instead of array data. That lasts until another read-array command is given or another operation completes. Two sticky error flags report failed or malformed operations, and a single command clears both of them.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, ready is 1, both error flags are 0, reads come from the array, every byte reads FFh and no block is locked.
- R2: A read strobe samples the address at a clock edge, and the byte at that address appears on read data after that same edge. Writing FFh selects array reads. Array reads then continue for any number of consecutive accesses.
- R3: Program is opcode 40h followed by a 16-bit write to an even address. When busy ends, the byte at the even address becomes old AND data[7:0], and the byte at the next address becomes old AND data[15:8].
- R4: A program data write to an odd address sets the program error flag and leaves the array unchanged. It does not make the block busy.
- R5: Erase is opcode 20h followed by D0h at any address inside a block. When busy ends, every byte of that block reads FFh and other blocks are unchanged.
- R6: A command sequence error sets both error flags on the edge of the bad write, and no operation starts. This covers a second write other than D0h for the D0h-confirmed opcodes, and a program data write that is not flagged 16-bit.
- R7: Ready goes low on the edge of the accepted second write and stays low for exactly BUSY_CYCLES cycles. Any bus write made while ready is low is ignored.
- R8: Opcode 77h followed by D0h locks the addressed block. A later program of a locked block sets the program error flag, and a later erase sets the erase error flag. In both cases the block's data is left unchanged.
- R9: Opcode 71h followed by D0h captures the lock bit of the addressed block. Until the next read-array command or operation, every read returns 01h if that block is locked and 00h if it is not.
- R10: Opcode 25h followed by D0h sets the erase error flag when busy ends if any byte of the addressed block is not FFh. A fully erased block leaves the flag unchanged.
- R11: A single write of 50h clears both error flags. Error flags otherwise stay set.
- R12: Only the low byte of a command write is decoded. The upper byte of a 16-bit command write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data; commands use bits 7:0 |
| bus_we | input | 1 | Write strobe |
| bus_wide | input | 1 | Marks the current write as a 16-bit access |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, updated on the edge that samples bus_re |
| stat_ready | output | 1 | 1 when no operation is running |
| stat_prog_err | output | 1 | Sticky program / sequence error flag |
| stat_erase_err | output | 1 | Sticky erase / blank / sequence error flag |

## Verification
Read data is due one edge after the strobe. The scoreboard therefore pops its expected byte a short delay after the clock edge at which the strobe was high. Sequence errors and odd-address errors are due right after the edge of the offending write, so they are sampled on the next falling edge. Results of busy operations are due on the edge where ready returns high. The bench counts how many falling edges ready stays low, compares that count with BUSY_CYCLES, and only then checks flags and reads back the array.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    typedef enum logic [2:0] {
        OP_IDLE, OP_PROG, OP_ERASE, OP_LOCK, OP_LOCKRD, OP_BLANK
    } op_e;

    typedef enum logic {RD_ARRAY, RD_LOCK} rdmode_e;

    localparam logic [7:0] CMD_READ    = 8'hFF;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_PROG    = 8'h40;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_LOCK    = 8'h77;
    localparam logic [7:0] CMD_LOCKRD  = 8'h71;
    localparam logic [7:0] CMD_BLANK   = 8'h25;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        cmd_i,
    input  logic              busy_i,
    output logic              start_o,
    output op_e               op_o,
    output logic              seq_err_o,
    output logic              odd_err_o,
    output logic              clr_o,
    output logic              read_o
);
    typedef struct packed {
        logic armed;
        op_e  op;
    } dec_t;

    dec_t d, q;

    always_comb begin
        d         = q;
        start_o   = 1'b0;
        seq_err_o = 1'b0;
        odd_err_o = 1'b0;
        clr_o     = 1'b0;
        read_o    = 1'b0;
        if (we_i && !busy_i) begin
            if (!q.armed) begin
                case (cmd_i)
                    CMD_READ:   read_o = 1'b1;
                    CMD_CLEAR:  clr_o  = 1'b1;
                    CMD_PROG:   begin d.armed = 1'b1; d.op = OP_PROG;   end
                    CMD_ERASE:  begin d.armed = 1'b1; d.op = OP_ERASE;  end
                    CMD_LOCK:   begin d.armed = 1'b1; d.op = OP_LOCK;   end
                    CMD_LOCKRD: begin d.armed = 1'b1; d.op = OP_LOCKRD; end
                    CMD_BLANK:  begin d.armed = 1'b1; d.op = OP_BLANK;  end
                    default: ;
                endcase
            end else begin
                d.armed = 1'b0;
                d.op    = OP_IDLE;
                if (q.op == OP_PROG) begin
                    if (!wide_i)        seq_err_o = 1'b1;
                    else if (addr_i[0]) odd_err_o = 1'b1;
                    else                start_o   = 1'b1;
                end else if (cmd_i == CMD_CONFIRM) begin
                    start_o = 1'b1;
                end else begin
                    seq_err_o = 1'b1;
                end
            end
        end
    end

    assign op_o = q.op;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{armed: 1'b0, op: OP_IDLE};
        else        q <= d;
    end

    // R7: an operation never starts while the previous one runs
    p_no_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !busy_i);
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int BUSY_CYCLES = 8,
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d      = q;
        busy_o = (q.cnt != '0);
        done_o = (q.cnt == CNT_W'(1));
        if (start_i)     d.cnt = CNT_W'(BUSY_CYCLES);
        else if (busy_o) d.cnt = q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

// File: rtl/flash_array.sv
module flash_array
    import flash_seq_pkg::*;
#(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_BYTES = 64,
    localparam int DEPTH  = NUM_BLOCKS * BLOCK_BYTES,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int OFF_W  = $clog2(BLOCK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       data_i,
    input  logic              done_i,
    output logic [7:0]        rd_byte_o,
    output op_e               cur_op_o,
    output logic              lock_o,
    output logic              prog_fail_o,
    output logic              erase_fail_o
);
    typedef struct packed {
        op_e                         op;
        logic [ADDR_W-1:0]           addr;
        logic [15:0]                 data;
        logic [NUM_BLOCKS-1:0]       lock;
        logic [DEPTH-1:0][7:0]       mem;
    } arr_t;

    arr_t d, q;
    logic [ADDR_W-OFF_W-1:0] blk;
    logic [ADDR_W-1:0]       hi_addr;
    logic                    locked;
    logic                    blank;

    assign blk     = q.addr[ADDR_W-1:OFF_W];
    assign hi_addr = {q.addr[ADDR_W-1:1], 1'b1};
    assign locked  = q.lock[blk];

    always_comb begin
        blank = 1'b1;
        for (int i = 0; i < BLOCK_BYTES; i++)
            if (q.mem[{blk, OFF_W'(i)}] != 8'hFF) blank = 1'b0;
    end

    always_comb begin
        d = q;
        if (start_i) begin
            d.op   = op_i;
            d.addr = addr_i;
            d.data = data_i;
        end
        if (done_i) begin
            d.op = OP_IDLE;
            case (q.op)
                OP_PROG: if (!locked) begin
                    d.mem[q.addr]  = q.mem[q.addr]  & q.data[7:0];
                    d.mem[hi_addr] = q.mem[hi_addr] & q.data[15:8];
                end
                OP_ERASE: if (!locked) begin
                    for (int i = 0; i < BLOCK_BYTES; i++)
                        d.mem[{blk, OFF_W'(i)}] = 8'hFF;
                end
                OP_LOCK: d.lock[blk] = 1'b1;
                default: ;
            endcase
        end
    end

    assign rd_byte_o    = q.mem[addr_i];
    assign cur_op_o     = q.op;
    assign lock_o       = locked;
    assign prog_fail_o  = done_i && (q.op == OP_PROG) && locked;
    assign erase_fail_o = done_i && (((q.op == OP_ERASE) && locked) ||
                                     ((q.op == OP_BLANK) && !blank));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.op   <= OP_IDLE;
            q.mem  <= '1;
        end else begin
            q <= d;
        end
    end

    // R8: a locked block keeps its contents through a failed program
    p_locked_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_fail_o |=> $stable(q.mem));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_BYTES = 64,
    parameter int BUSY_CYCLES = 8,
    localparam int ADDR_W = $clog2(NUM_BLOCKS * BLOCK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic              bus_re,
    output logic [7:0]        bus_rdata,
    output logic              stat_ready,
    output logic              stat_prog_err,
    output logic              stat_erase_err
);
    typedef struct packed {
        logic       prog_err;
        logic       erase_err;
        rdmode_e    mode;
        logic       lock_seen;
        logic [7:0] rdata;
    } top_t;

    top_t d, q;

    logic busy, done, start, seq_err, odd_err, clr, rd_cmd;
    logic lock_bit, prog_fail, erase_fail;
    op_e  dec_op, cur_op;
    logic [7:0] rd_byte;

    flash_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we), .wide_i(bus_wide),
        .addr_i(bus_addr), .cmd_i(bus_wdata[7:0]), .busy_i(busy),
        .start_o(start), .op_o(dec_op), .seq_err_o(seq_err),
        .odd_err_o(odd_err), .clr_o(clr), .read_o(rd_cmd)
    );

    flash_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done)
    );

    flash_array #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) u_arr (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(dec_op),
        .addr_i(bus_addr), .data_i(bus_wdata), .done_i(done),
        .rd_byte_o(rd_byte), .cur_op_o(cur_op), .lock_o(lock_bit),
        .prog_fail_o(prog_fail), .erase_fail_o(erase_fail)
    );

    always_comb begin
        d = q;
        if (clr) begin
            d.prog_err  = 1'b0;
            d.erase_err = 1'b0;
        end
        if (seq_err) begin
            d.prog_err  = 1'b1;
            d.erase_err = 1'b1;
        end
        if (odd_err || prog_fail) d.prog_err  = 1'b1;
        if (erase_fail)           d.erase_err = 1'b1;
        if (rd_cmd) d.mode = RD_ARRAY;
        if (done) begin
            d.mode      = (cur_op == OP_LOCKRD) ? RD_LOCK : RD_ARRAY;
            d.lock_seen = lock_bit;
        end
        if (bus_re)
            d.rdata = (q.mode == RD_LOCK) ? {7'd0, q.lock_seen} : rd_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{prog_err: 1'b0, erase_err: 1'b0, mode: RD_ARRAY,
                           lock_seen: 1'b0, rdata: 8'hFF};
        else        q <= d;
    end

    assign bus_rdata      = q.rdata;
    assign stat_ready     = !busy;
    assign stat_prog_err  = q.prog_err;
    assign stat_erase_err = q.erase_err;

    p_seq_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> (stat_prog_err && stat_erase_err));
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!stat_prog_err && !stat_erase_err));
    p_odd_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        odd_err |=> (stat_ready && stat_prog_err));
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
    localparam int BUSY = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0, bus_wide = 1'b0, bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        stat_ready, stat_prog_err, stat_erase_err;

    int n_cmp = 0, n_bad = 0;
    bit done_flag = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    flash_cmd_seq #(.NUM_BLOCKS(4), .BLOCK_BYTES(64), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_wide(bus_wide), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .stat_ready(stat_ready),
        .stat_prog_err(stat_prog_err), .stat_erase_err(stat_erase_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: read data is due right after the sampling edge
    always @(posedge clk) begin
        if (bus_re && rst_n) begin
            #2;
            if (exp_q.size() == 0) chk("R2 scoreboard underrun", 1, 0);
            else chk(tag_q.pop_front(), int'(bus_rdata), int'(exp_q.pop_front()));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] dt, input logic wide);
        @(negedge clk);
        bus_addr = a; bus_wdata = dt; bus_we = 1'b1; bus_wide = wide;
        @(negedge clk);
        bus_we = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wait_ready(output int lowc);
        lowc = 0;
        while (!stat_ready) begin
            lowc++;
            @(negedge clk);
        end
    endtask

    task automatic flags(input string tag, input logic pe, input logic ee);
        chk({tag, " prog_err"}, int'(stat_prog_err), int'(pe));
        chk({tag, " erase_err"}, int'(stat_erase_err), int'(ee));
    endtask

    task automatic op2(input logic [7:0] opc, input logic [7:0] a);
        int c;
        wr(a, {8'h00, opc}, 1'b0);
        wr(a, 16'h00D0, 1'b0);
        wait_ready(c);
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", int'(stat_ready), 1);
        flags("R1", 1'b0, 1'b0);
        rd(8'h00, 8'hFF, "R1 erased 00");
        rd(8'hFF, 8'hFF, "R1 erased FF");

        // R3 program, with busy length R7
        wr(8'h10, 16'h0040, 1'b0);
        wr(8'h10, 16'h1234, 1'b1);
        chk("R7 ready low after start", int'(stat_ready), 0);
        wait_ready(c);
        chk("R7 busy length", c, BUSY);
        flags("R3", 1'b0, 1'b0);
        rd(8'h10, 8'h34, "R3 low byte");
        rd(8'h11, 8'h12, "R3 high byte");
        rd(8'h10, 8'h34, "R2 repeated read");
        wr(8'h10, 16'h0040, 1'b0);
        wr(8'h10, 16'hF0F0, 1'b1);
        wait_ready(c);
        rd(8'h10, 8'h30, "R3 AND low");
        rd(8'h11, 8'h10, "R3 AND high");

        // R12 upper command byte ignored
        wr(8'h50, 16'hAB40, 1'b1);
        wr(8'h50, 16'h5566, 1'b1);
        wait_ready(c);
        chk("R12 busy length", c, BUSY);
        rd(8'h50, 8'h66, "R12 low byte");
        rd(8'h51, 8'h55, "R12 high byte");

        // R4 odd address
        wr(8'h51, 16'h0040, 1'b0);
        wr(8'h51, 16'h0000, 1'b1);
        chk("R4 stays ready", int'(stat_ready), 1);
        flags("R4", 1'b1, 1'b0);
        rd(8'h51, 8'h55, "R4 unchanged");
        wr(8'h00, 16'h0050, 1'b0);
        flags("R11 clear", 1'b0, 1'b0);

        // R6 narrow program data and bad confirm
        wr(8'h50, 16'h0040, 1'b0);
        wr(8'h50, 16'h0000, 1'b0);
        chk("R6 narrow no busy", int'(stat_ready), 1);
        flags("R6 narrow", 1'b1, 1'b1);
        rd(8'h50, 8'h66, "R6 narrow unchanged");
        wr(8'h00, 16'h0050, 1'b0);
        wr(8'h10, 16'h0020, 1'b0);
        wr(8'h10, 16'h0033, 1'b0);
        chk("R6 bad confirm no busy", int'(stat_ready), 1);
        flags("R6 confirm", 1'b1, 1'b1);
        rd(8'h10, 8'h30, "R6 no erase");
        wr(8'h00, 16'h0050, 1'b0);
        flags("R11 clear again", 1'b0, 1'b0);

        // R7 writes ignored while busy
        wr(8'h30, 16'h0040, 1'b0);
        wr(8'h30, 16'h0000, 1'b1);
        wr(8'h10, 16'h0020, 1'b0);
        wr(8'h10, 16'h00D0, 1'b0);
        chk("R7 still busy", int'(stat_ready), 0);
        wait_ready(c);
        rd(8'h30, 8'h00, "R7 program done");
        rd(8'h10, 8'h30, "R7 erase ignored");
        chk("R7 no follow-on busy", int'(stat_ready), 1);

        // R10 blank check
        op2(8'h25, 8'h05);
        flags("R10 not blank", 1'b0, 1'b1);
        wr(8'h00, 16'h0050, 1'b0);
        op2(8'h25, 8'hC7);
        flags("R10 blank", 1'b0, 1'b0);

        // R5 erase
        op2(8'h20, 8'h3F);
        flags("R5", 1'b0, 1'b0);
        rd(8'h10, 8'hFF, "R5 erased 10");
        rd(8'h30, 8'hFF, "R5 erased 30");
        rd(8'h50, 8'h66, "R5 other block kept");
        op2(8'h25, 8'h00);
        flags("R5 blank after erase", 1'b0, 1'b0);

        // R8 / R9 lock
        op2(8'h77, 8'h40);
        op2(8'h71, 8'h40);
        rd(8'h40, 8'h01, "R9 locked");
        rd(8'h99, 8'h01, "R9 persists");
        op2(8'h71, 8'h80);
        rd(8'h80, 8'h00, "R9 unlocked");
        wr(8'h00, 16'h00FF, 1'b0);
        rd(8'h50, 8'h66, "R2 back to array");
        wr(8'h52, 16'h0040, 1'b0);
        wr(8'h52, 16'h0000, 1'b1);
        wait_ready(c);
        flags("R8 program locked", 1'b1, 1'b0);
        rd(8'h52, 8'hFF, "R8 program blocked");
        wr(8'h00, 16'h0050, 1'b0);
        op2(8'h20, 8'h45);
        flags("R8 erase locked", 1'b0, 1'b1);
        rd(8'h50, 8'h66, "R8 erase blocked");

        repeat (3) @(negedge clk);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        summary();
    end
endmodule